// File: doc/BRIEF.md
# Merging Store Buffer with Read-Conflict Probe

This block sits between a write-through data cache and main memory. The processor hands it stores and carries on running. The buffer writes the queued stores out to memory in the background, one block at a time, through a request/acknowledge port. Each slot holds one block address, the data of every word in that block, and a byte-enable mask. A new store to a block that already has a slot is folded into that slot, so a burst of stores to one block costs a single memory write.

When the cache misses on a read, the miss address is presented on the probe port before memory is read. The probe compares the address against every pending block in parallel and raises a conflict flag if one matches. If every byte of the requested word is present in that slot, the word is returned along with the flag. Otherwise the requester must wait until the slot has been written out. The probe answers in the same cycle. It reflects the buffer contents as registered at the start of that cycle.

Slots drain in the order they were allocated. The slot at the head of the queue is always the one being written. To keep its data stable, a store that targets the head block is stalled. All addresses on this block are word addresses: the low bits select the word within the block, and the remaining bits form the block address.

Top module: `wbuf_merge`

## Requirements
- R1: After reset the buffer is empty: `mem_req` is low, `st_ready` is high and no probe reports a conflict.
- R2: While the buffer is empty, a store is always accepted (`st_ready` high). A store to a block that is not pending takes a free slot, and up to DEPTH distinct blocks are accepted without any memory write.
- R3: A store whose block matches a pending slot other than the head is accepted even when all slots are occupied. It adds no memory write: its bytes reach memory inside the existing slot's single write.
- R4: When all slots are occupied, no slot retires in that cycle, and the store's block is not pending, `st_ready` is low.
- R5: A store whose block equals the block currently offered on `mem_blk` is refused (`st_ready` low) until that slot has retired. Once it is accepted, it goes into a new slot.
- R6: `mem_req` is held high with `mem_blk`, `mem_data` and `mem_be` unchanged until `mem_ack`. The slot is freed at the clock edge where `mem_ack` is high.
- R7: Memory writes leave in the order in which their slots were allocated, oldest first.
- R8: Only written bytes reach memory. `mem_be` bit w*BYTES+b covers byte b of word w. `mem_data` bits [w*DATA_W +: DATA_W] carry word w. `mem_wmask` bit w is set exactly when some byte of word w was written.
- R9: `probe_conflict` is high exactly when `probe_valid` is high and the block of `probe_addr` matches a pending slot.
- R10: On a conflict, `probe_fwd_valid` is high with the newest value on `probe_fwd_data` only when all bytes of the probed word are present in the slot. Otherwise `probe_fwd_valid` is low.
- R11: When all slots are occupied and `mem_ack` retires the head, a store to a new block is accepted in that same cycle.
- R12: Once the buffer has drained, memory holds, for every byte ever stored, the value of the last store to that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request present |
| st_ready | output | 1 | Store accepted at this edge when st_valid is high |
| st_waddr | input | WADDR_W | Store word address (block, then word index in low bits) |
| st_data | input | DATA_W | Store data |
| st_be | input | DATA_W/8 | Store byte enables, bit b for bits [8b+7:8b] |
| probe_valid | input | 1 | Read-miss probe present |
| probe_waddr | input | WADDR_W | Read-miss word address |
| probe_conflict | output | 1 | Probed block is pending in the buffer |
| probe_fwd_valid | output | 1 | Probed word fully present and forwarded |
| probe_fwd_data | output | DATA_W | Forwarded word |
| mem_req | output | 1 | Memory write request for the oldest slot |
| mem_blk | output | WADDR_W-log2(WORDS) | Block address of the write |
| mem_data | output | WORDS*DATA_W | Block data, word w at [w*DATA_W +: DATA_W] |
| mem_be | output | WORDS*DATA_W/8 | Byte enables for the block |
| mem_wmask | output | WORDS | Words with at least one enabled byte |
| mem_ack | input | 1 | Memory accepted the write; slot retires |

## Verification
A corrupted head pointer or occupancy count appears at the memory port within one write. Either a block leaves out of allocation order, or a write repeats or goes missing, and the ordered write log catches that once the drain completes. A merge that lands in the wrong slot, or a byte mask that is not cleared when a slot is reused, shows up as a wrong or missing byte in the memory image after the drain. It shows up immediately as a wrong forwarded word or flag on the probe port. A wrong readiness decision is visible the same cycle on `st_ready` in the full, head-hit and retire-while-full cases.

// File: rtl/wbuf_merge_pkg.sv
package wbuf_merge_pkg;
    localparam int unsigned WB_WADDR_W = 30;
    localparam int unsigned WB_DATA_W  = 32;
    localparam int unsigned WB_WORDS   = 4;
    localparam int unsigned WB_DEPTH   = 4;

    // circular pointer advance over a queue of the given depth
    function automatic int unsigned wb_next(input int unsigned p, input int unsigned depth);
        return (p + 1 == depth) ? 0 : p + 1;
    endfunction
endpackage

// File: rtl/wbuf_cam.sv
module wbuf_cam #(
    parameter int unsigned N = 4,
    parameter int unsigned W = 28
) (
    input  logic [N-1:0]        vld,
    input  logic [N-1:0][W-1:0] keys,
    input  logic [W-1:0]        probe,
    output logic [N-1:0]        hit
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit[i] = vld[i] && (keys[i] == probe);
    end
endmodule

// File: rtl/wbuf_onehot_idx.sv
module wbuf_onehot_idx #(
    parameter int unsigned N  = 4,
    parameter int unsigned IW = 2
) (
    input  logic [N-1:0]  onehot,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (onehot[i]) idx = idx | IW'(i);
        end
    end
endmodule

// File: rtl/wbuf_merge.sv
module wbuf_merge
    import wbuf_merge_pkg::*;
#(
    parameter int unsigned WADDR_W = WB_WADDR_W,
    parameter int unsigned DATA_W  = WB_DATA_W,
    parameter int unsigned WORDS   = WB_WORDS,
    parameter int unsigned DEPTH   = WB_DEPTH,
    localparam int unsigned BYTES  = DATA_W / 8,
    localparam int unsigned WSEL_W = $clog2(WORDS),
    localparam int unsigned BLK_W  = WADDR_W - WSEL_W,
    localparam int unsigned LINE_W = WORDS * DATA_W,
    localparam int unsigned LBE_W  = WORDS * BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    output logic              st_ready,
    input  logic [WADDR_W-1:0] st_waddr,
    input  logic [DATA_W-1:0] st_data,
    input  logic [BYTES-1:0]  st_be,
    input  logic              probe_valid,
    input  logic [WADDR_W-1:0] probe_waddr,
    output logic              probe_conflict,
    output logic              probe_fwd_valid,
    output logic [DATA_W-1:0] probe_fwd_data,
    output logic              mem_req,
    output logic [BLK_W-1:0]  mem_blk,
    output logic [LINE_W-1:0] mem_data,
    output logic [LBE_W-1:0]  mem_be,
    output logic [WORDS-1:0]  mem_wmask,
    input  logic              mem_ack
);
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0]             vld;
        logic [DEPTH-1:0][BLK_W-1:0]  blk;
        logic [DEPTH-1:0][LINE_W-1:0] data;
        logic [DEPTH-1:0][LBE_W-1:0]  be;
        logic [IDX_W-1:0]             head;
        logic [IDX_W-1:0]             tail;
        logic [CNT_W-1:0]             cnt;
    } wb_state_t;

    wb_state_t s_q, s_d;

    logic [BLK_W-1:0]  st_blk, pr_blk;
    logic [WSEL_W-1:0] st_word, pr_word;
    logic [DEPTH-1:0]  st_hit, pr_hit;
    logic [IDX_W-1:0]  st_idx, pr_idx;
    logic              retire_d, accept_d, alloc_d, hit_any_d;
    logic [IDX_W-1:0]  tgt_d;
    logic [BYTES-1:0]  pr_word_be;

    assign st_blk  = st_waddr[WADDR_W-1:WSEL_W];
    assign st_word = st_waddr[WSEL_W-1:0];
    assign pr_blk  = probe_waddr[WADDR_W-1:WSEL_W];
    assign pr_word = probe_waddr[WSEL_W-1:0];

    wbuf_cam #(.N(DEPTH), .W(BLK_W)) u_st_cam (
        .vld(s_q.vld), .keys(s_q.blk), .probe(st_blk), .hit(st_hit)
    );
    wbuf_cam #(.N(DEPTH), .W(BLK_W)) u_pr_cam (
        .vld(s_q.vld), .keys(s_q.blk), .probe(pr_blk), .hit(pr_hit)
    );
    wbuf_onehot_idx #(.N(DEPTH), .IW(IDX_W)) u_st_idx (.onehot(st_hit), .idx(st_idx));
    wbuf_onehot_idx #(.N(DEPTH), .IW(IDX_W)) u_pr_idx (.onehot(pr_hit), .idx(pr_idx));

    // memory side always serves the oldest slot
    assign mem_req  = (s_q.cnt != '0);
    assign mem_blk  = s_q.blk[s_q.head];
    assign mem_data = s_q.data[s_q.head];
    assign mem_be   = s_q.be[s_q.head];
    for (genvar w = 0; w < WORDS; w++) begin : g_wmask
        assign mem_wmask[w] = |s_q.be[s_q.head][w*BYTES +: BYTES];
    end

    always_comb begin
        s_d       = s_q;
        retire_d  = mem_req && mem_ack;
        hit_any_d = |st_hit;
        // the head slot is in flight: folding into it could lose bytes
        st_ready  = !st_hit[s_q.head] &&
                    (hit_any_d || (s_q.cnt < CNT_W'(DEPTH)) || retire_d);
        accept_d  = st_valid && st_ready;
        alloc_d   = accept_d && !hit_any_d;
        tgt_d     = hit_any_d ? st_idx : s_q.tail;

        if (retire_d) begin
            s_d.vld[s_q.head] = 1'b0;
            s_d.be[s_q.head]  = '0;
            s_d.head          = IDX_W'(wb_next(int'(s_q.head), DEPTH));
        end
        if (alloc_d) begin
            s_d.vld[s_q.tail] = 1'b1;
            s_d.blk[s_q.tail] = st_blk;
            s_d.be[s_q.tail]  = '0;
            s_d.tail          = IDX_W'(wb_next(int'(s_q.tail), DEPTH));
        end
        if (accept_d) begin
            for (int b = 0; b < BYTES; b++) begin
                if (st_be[b]) begin
                    s_d.data[tgt_d][int'(st_word)*DATA_W + b*8 +: 8] = st_data[b*8 +: 8];
                    s_d.be[tgt_d][int'(st_word)*BYTES + b]           = 1'b1;
                end
            end
        end
        s_d.cnt = s_q.cnt + CNT_W'(alloc_d) - CNT_W'(retire_d);

        pr_word_be      = s_q.be[pr_idx][int'(pr_word)*BYTES +: BYTES];
        probe_conflict  = probe_valid && (|pr_hit);
        probe_fwd_valid = probe_conflict && (&pr_word_be);
        probe_fwd_data  = probe_fwd_valid ?
                          s_q.data[pr_idx][int'(pr_word)*DATA_W +: DATA_W] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/wbuf_merge_chk.sv
module wbuf_merge_chk #(
    parameter int unsigned BLK_W  = 28,
    parameter int unsigned LINE_W = 128,
    parameter int unsigned LBE_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              st_valid,
    input logic              st_ready,
    input logic [BLK_W-1:0]  st_blk,
    input logic              probe_valid,
    input logic              probe_conflict,
    input logic              probe_fwd_valid,
    input logic              mem_req,
    input logic              mem_ack,
    input logic [BLK_W-1:0]  mem_blk,
    input logic [LINE_W-1:0] mem_data,
    input logic [LBE_W-1:0]  mem_be
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> !mem_req && !probe_conflict);

    assert_empty_accepts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_req |-> st_ready);

    assert_head_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && st_valid && (st_blk == mem_blk) |-> !st_ready);

    assert_hold_until_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_blk) && $stable(mem_data) && $stable(mem_be));

    assert_head_advances_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack |=> !mem_req || (mem_blk != $past(mem_blk)));

    assert_probe_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !probe_valid |-> !probe_conflict);

    assert_fwd_needs_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        probe_fwd_valid |-> probe_conflict);
endmodule

bind wbuf_merge wbuf_merge_chk #(
    .BLK_W(BLK_W), .LINE_W(LINE_W), .LBE_W(LBE_W)
) u_wbuf_merge_chk (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_blk(st_waddr[WADDR_W-1:WSEL_W]), .probe_valid(probe_valid),
    .probe_conflict(probe_conflict), .probe_fwd_valid(probe_fwd_valid),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_blk(mem_blk),
    .mem_data(mem_data), .mem_be(mem_be)
);

// File: tb/wbuf_merge_bench.sv
`timescale 1ns/1ps
module wbuf_merge_bench;
    localparam int WADDR_W = 30, DATA_W = 32, WORDS = 4, BYTES = 4;
    localparam int BLK_W = 28, LINE_W = 128, LBE_W = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic st_valid = 1'b0, st_ready;
    logic [WADDR_W-1:0] st_waddr = '0;
    logic [DATA_W-1:0] st_data = '0;
    logic [BYTES-1:0] st_be = '0;
    logic probe_valid = 1'b0, probe_conflict, probe_fwd_valid;
    logic [WADDR_W-1:0] probe_waddr = '0;
    logic [DATA_W-1:0] probe_fwd_data;
    logic mem_req, mem_ack;
    logic [BLK_W-1:0] mem_blk;
    logic [LINE_W-1:0] mem_data;
    logic [LBE_W-1:0] mem_be;
    logic [WORDS-1:0] mem_wmask;

    always #2 clk = ~clk;

    wbuf_merge u_wbuf_merge (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
        .st_waddr(st_waddr), .st_data(st_data), .st_be(st_be),
        .probe_valid(probe_valid), .probe_waddr(probe_waddr),
        .probe_conflict(probe_conflict), .probe_fwd_valid(probe_fwd_valid),
        .probe_fwd_data(probe_fwd_data), .mem_req(mem_req), .mem_blk(mem_blk),
        .mem_data(mem_data), .mem_be(mem_be), .mem_wmask(mem_wmask), .mem_ack(mem_ack)
    );

    int checks = 0, fails = 0;
    bit done = 0;
    logic [7:0] exp_img [16][16];
    logic [7:0] mem_img [16][16];
    int lat = 0;
    bit ack_en = 0;
    int wcnt, wr_cnt;
    logic [BLK_W-1:0] wr_blk [64];
    logic [WORDS-1:0] wr_mask [64];

    // memory stub: acknowledges after lat waiting cycles, logs every write
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0; wcnt <= 0; wr_cnt <= 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0; wcnt <= 0;
            for (int b = 0; b < LBE_W; b++)
                if (mem_be[b]) mem_img[mem_blk[3:0]][b] <= mem_data[b*8 +: 8];
            if (wr_cnt < 64) begin
                wr_blk[wr_cnt] <= mem_blk; wr_mask[wr_cnt] <= mem_wmask;
            end
            wr_cnt <= wr_cnt + 1;
        end else if (mem_req && ack_en) begin
            if (wcnt >= lat) mem_ack <= 1'b1;
            else wcnt <= wcnt + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [WADDR_W-1:0] mk_addr(input int blk, input int w);
        return {BLK_W'(blk), 2'(w)};
    endfunction

    function automatic logic [31:0] exp_word(input int blk, input int w);
        return {exp_img[blk][w*4+3], exp_img[blk][w*4+2], exp_img[blk][w*4+1], exp_img[blk][w*4]};
    endfunction

    task automatic do_store(input int blk, input int w, input logic [31:0] d,
                            input logic [3:0] be, input int max_wait,
                            output bit acc, output bit with_ack);
        bit r, a;
        acc = 0; with_ack = 0;
        @(negedge clk);
        st_valid = 1; st_waddr = mk_addr(blk, w); st_data = d; st_be = be;
        for (int i = 0; i < max_wait; i++) begin
            #1; r = st_ready; a = mem_ack;
            @(posedge clk);
            if (r) begin acc = 1; with_ack = a; break; end
            @(negedge clk);
        end
        #1; st_valid = 0;
        if (acc)
            for (int b = 0; b < 4; b++)
                if (be[b]) exp_img[blk][w*4+b] = d[b*8 +: 8];
    endtask

    task automatic try_ready(input int blk, input int w, output bit rdy);
        @(negedge clk);
        st_valid = 1; st_waddr = mk_addr(blk, w); st_data = 32'hDEAD_BEEF; st_be = 4'hF;
        #1; rdy = st_ready;
        st_valid = 0;
    endtask

    task automatic do_probe(input bit pv, input int blk, input int w,
                            output bit conf, output bit fv, output logic [31:0] fd);
        @(negedge clk);
        probe_valid = pv; probe_waddr = mk_addr(blk, w);
        #1; conf = probe_conflict; fv = probe_fwd_valid; fd = probe_fwd_data;
        probe_valid = 0;
    endtask

    task automatic wait_drain(input string req);
        int n = 0;
        @(negedge clk);
        while (mem_req && n < 2000) begin @(negedge clk); n++; end
        check(!mem_req, req, "buffer drained", mem_req, 0);
    endtask

    task automatic check_image(input string req);
        int bad = 0;
        for (int k = 0; k < 16; k++)
            for (int b = 0; b < 16; b++)
                if (mem_img[k][b] !== exp_img[k][b]) bad++;
        check(bad == 0, req, "memory image mismatching bytes", bad, 0);
    endtask

    task automatic store_ok(input int blk, input int w, input logic [31:0] d,
                            input logic [3:0] be, input string req);
        bit acc, wa;
        do_store(blk, w, d, be, 2, acc, wa);
        check(acc, req, "store accepted", acc, 1);
    endtask

    task automatic t_reset;
        bit c, f; logic [31:0] d;
        @(negedge clk); #1;
        check(st_ready == 1, "R1", "st_ready after reset", st_ready, 1);
        check(mem_req == 0, "R1", "mem_req after reset", mem_req, 0);
        do_probe(1, 3, 0, c, f, d);
        check(c == 0, "R1", "probe conflict after reset", c, 0);
    endtask

    // merge into a non-head slot, partial words, one write per block
    task automatic t_merge;
        int base;
        ack_en = 0; base = wr_cnt;
        store_ok(1, 0, 32'h1111_0000, 4'hF, "R2");
        store_ok(2, 1, 32'h2222_0001, 4'hF, "R2");
        store_ok(2, 3, 32'hAABB_CCDD, 4'b0011, "R3");
        store_ok(2, 1, 32'h5566_7788, 4'b1000, "R3");
        lat = 1; ack_en = 1;
        wait_drain("R3");
        check(wr_cnt - base == 2, "R3", "write count for merged stores", wr_cnt - base, 2);
        check(wr_blk[base+1] == 2, "R7", "second write block", wr_blk[base+1], 2);
        check(wr_mask[base+1] == 4'b1010, "R8", "word mask of merged slot", wr_mask[base+1], 4'b1010);
        check(wr_mask[base] == 4'b0001, "R8", "word mask of single-word slot", wr_mask[base], 4'b0001);
        check_image("R12");
    endtask

    task automatic t_full;
        bit r; int base;
        ack_en = 0; base = wr_cnt;
        store_ok(3, 0, 32'h3030_3030, 4'hF, "R2");
        store_ok(7, 0, 32'h7070_7070, 4'hF, "R2");
        store_ok(1, 0, 32'h0101_0101, 4'hF, "R2");
        store_ok(12, 0, 32'hC0C0_C0C0, 4'hF, "R2");
        try_ready(9, 0, r);
        check(r == 0, "R4", "ready with full buffer, new block", r, 0);
        try_ready(7, 2, r);
        check(r == 1, "R3", "ready for merge while full", r, 1);
        store_ok(7, 2, 32'h7272_7272, 4'hF, "R3");
        try_ready(3, 1, r);
        check(r == 0, "R5", "ready for head block", r, 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
            check(mem_req && mem_blk == 3, "R6", "head held without ack", mem_blk, 3);
        end
        lat = 2; ack_en = 1;
        wait_drain("R7");
        check(wr_cnt - base == 4, "R3", "writes after merge while full", wr_cnt - base, 4);
        check(wr_blk[base] == 3 && wr_blk[base+1] == 7, "R7", "drain order first two",
              {wr_blk[base], wr_blk[base+1]}, {28'd3, 28'd7});
        check(wr_blk[base+2] == 1 && wr_blk[base+3] == 12, "R7", "drain order last two",
              {wr_blk[base+2], wr_blk[base+3]}, {28'd1, 28'd12});
        check(wr_mask[base+1] == 4'b0101, "R8", "mask of block 7", wr_mask[base+1], 4'b0101);
        check_image("R12");
    endtask

    task automatic t_same_cycle;
        bit acc, wa; int base;
        ack_en = 0; base = wr_cnt;
        store_ok(2, 2, 32'h0202_0202, 4'hF, "R2");
        store_ok(4, 2, 32'h0404_0404, 4'hF, "R2");
        store_ok(6, 2, 32'h0606_0606, 4'hF, "R2");
        store_ok(8, 2, 32'h0808_0808, 4'hF, "R2");
        lat = 3; ack_en = 1;
        do_store(10, 2, 32'h1010_1010, 4'hF, 30, acc, wa);
        check(acc, "R11", "store accepted when full", acc, 1);
        check(wa, "R11", "accepted in retire cycle", wa, 1);
        wait_drain("R11");
        check(wr_cnt - base == 5, "R11", "write count", wr_cnt - base, 5);
        check(wr_blk[base+4] == 10, "R7", "newest slot written last", wr_blk[base+4], 10);
        check_image("R12");
    endtask

    task automatic t_probe;
        bit c, f, acc, wa, r; logic [31:0] d; int base;
        ack_en = 0; base = wr_cnt;
        store_ok(9, 0, 32'h9999_0000, 4'hF, "R2");
        store_ok(5, 2, 32'hCAFE_F00D, 4'hF, "R2");
        store_ok(5, 0, 32'h0000_1234, 4'b0011, "R3");
        do_probe(1, 5, 2, c, f, d);
        check(c == 1, "R9", "conflict on pending block", c, 1);
        check(f == 1 && d == exp_word(5, 2), "R10", "forward full word", d, exp_word(5, 2));
        do_probe(1, 5, 0, c, f, d);
        check(c == 1 && f == 0, "R10", "partial word not forwarded", {c, f}, 2'b10);
        do_probe(1, 5, 1, c, f, d);
        check(c == 1 && f == 0, "R10", "absent word not forwarded", {c, f}, 2'b10);
        do_probe(1, 11, 2, c, f, d);
        check(c == 0, "R9", "no conflict on other block", c, 0);
        do_probe(0, 5, 2, c, f, d);
        check(c == 0, "R9", "no conflict without probe_valid", c, 0);
        try_ready(9, 1, r);
        check(r == 0, "R5", "ready for head block 9", r, 0);
        lat = 1; ack_en = 1;
        do_store(9, 1, 32'h9191_9191, 4'hF, 40, acc, wa);
        check(acc, "R5", "head-block store accepted after retire", acc, 1);
        wait_drain("R12");
        check(wr_cnt - base == 3, "R5", "head-block store got a new slot", wr_cnt - base, 3);
        check(wr_blk[base+2] == 9 && wr_mask[base+2] == 4'b0010, "R8", "late block-9 write",
              {wr_blk[base+2], wr_mask[base+2]}, {28'd9, 4'b0010});
        do_probe(1, 5, 2, c, f, d);
        check(c == 0, "R9", "no conflict after drain", c, 0);
        check_image("R12");
    endtask

    initial begin
        for (int k = 0; k < 16; k++)
            for (int b = 0; b < 16; b++) begin
                exp_img[k][b] = 8'h00; mem_img[k][b] = 8'h00;
            end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        t_reset();
        t_merge();
        t_full();
        t_same_cycle();
        t_probe();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule